// File: doc/BRIEF.md
# Two-Stage Fine-Resolution Pulse-Width Modulator

This block produces a single-phase pulse-width modulated output whose duty cycle is set by an unsigned 10-bit word. The resolution comes from two stages. A coarse stage runs an 8-bit counter on the fast clock and compares it with the upper eight duty bits. This gives one coarse step per clock, 5 ns at the intended 200 MHz clock, and a period of 256 steps (1.28 us). A fine stage uses the two lower duty bits to split the single clock cycle where the pulse ends into four quarter-slots of 1.25 ns.

Every clock cycle the block emits a 4-bit slot word meant for an external 4:1 output serializer, which shifts the word out most significant bit first. In every cycle except one, the word repeats the coarse level in all four slots. In the cycle where the counter reaches the coarse threshold, the word carries a partial pulse, so the serialized waveform stays high for exactly the duty word's number of quarter-slots. A period-start strobe marks the first output cycle of each period. The duty word is captured only on the last cycle of a period, so a running period is never altered.

Top module: `dpwm_hybrid`

## Requirements
- R1: While `rst` is high, `coarse_o`, `slot_word_o` and `period_start_o` are low. The held duty value is cleared, so the first period after reset produces no high slot.
- R2: `period_start_o` is high for one cycle in every 256 cycles and never on two cycles in a row. Each period spans exactly 256 output cycles.
- R3: `coarse_o` is high in the first `duty_i[9:2]` output cycles of a period and low in the rest.
- R4: Whenever `coarse_o` is high, `slot_word_o` is 4'b1111. In cycles other than the edge cycle where `coarse_o` is low, `slot_word_o` is 4'b0000.
- R5: In the edge cycle, which is output cycle number `duty_i[9:2]` of the period counting from 0, `slot_word_o` has its upper `duty_i[1:0]` bits high and its other bits low. Bit 3 is the first slot in time. At most one word per period is neither 4'b0000 nor 4'b1111.
- R6: The waveform rebuilt by reading each word from bit 3 down to bit 0 forms one contiguous high pulse that starts at the first slot of the period. Its length is exactly the duty word's number of slots.
- R7: A duty word of 0 gives a period with every slot low. A duty word of 1023 gives 1023 high slots out of 1024.
- R8: `duty_i` is sampled only on the last counter cycle of a period and applies from the next period on. Changes at any other time do not affect the period being output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast modulator clock, one coarse step per cycle |
| rst | input | 1 | Synchronous active-high reset |
| duty_i | input | 10 | Unsigned duty word in quarter-slots |
| coarse_o | output | 1 | Registered coarse wave |
| slot_word_o | output | 4 | Registered slot word for the serializer, bit 3 first in time |
| period_start_o | output | 1 | High in the first output cycle of each period |

## Verification
The duty words used are the following. Zero and the values 1 to 3 place the edge in the very first counter cycle. Multiples of four have no partial word. Values 5 and 7 separate the coarse and fine contributions. The midpoints 511 and 512 sit on either side of a coarse step. The values 1020, 1022 and 1023 cover the top of the range, where the edge falls in the last counter cycle. Each period is rebuilt slot by slot and compared for total length, coarse length, contiguity and the number of partial words. This tells a wrong comparison apart from a wrong or reversed fine pattern. A duty change made in the middle of a period shows whether the capture point is the period wrap.

// File: rtl/dpwm_pkg.sv
package dpwm_pkg;
  localparam int unsigned DUTY_W_DEF = 10;
  localparam int unsigned FINE_W_DEF = 2;

  // classification of one coarse cycle relative to the threshold
  typedef enum logic [1:0] {
    SLOT_LOW  = 2'd0,
    SLOT_HIGH = 2'd1,
    SLOT_EDGE = 2'd2
  } slot_kind_e;
endpackage

// File: rtl/dpwm_period_ctr.sv
module dpwm_period_ctr #(
  parameter int unsigned DUTY_W = dpwm_pkg::DUTY_W_DEF,
  parameter int unsigned FINE_W = dpwm_pkg::FINE_W_DEF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DUTY_W-1:0] duty_i,
  output logic [DUTY_W-FINE_W-1:0] cnt_o,
  output logic [DUTY_W-1:0] duty_o,
  output logic              wrap_o
);
  localparam int unsigned CW = DUTY_W - FINE_W;
  localparam logic [CW-1:0] LAST = '1;

  logic [CW-1:0]     cnt_q;
  logic [DUTY_W-1:0] duty_q;

  assign wrap_o = (cnt_q == LAST);
  assign cnt_o  = cnt_q;
  assign duty_o = duty_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      duty_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
      if (wrap_o) duty_q <= duty_i;
    end
  end

  assert_counter_wraps_R2: assert property (@(posedge clk) disable iff (rst)
    (cnt_q == LAST) |=> (cnt_q == '0));

  assert_duty_held_midperiod_R8: assert property (@(posedge clk) disable iff (rst)
    (cnt_q != LAST) |=> $stable(duty_q));
endmodule

// File: rtl/dpwm_coarse_cmp.sv
module dpwm_coarse_cmp #(
  parameter int unsigned CW = 8
) (
  input  logic [CW-1:0]        cnt_i,
  input  logic [CW-1:0]        thresh_i,
  output dpwm_pkg::slot_kind_e kind_o
);
  import dpwm_pkg::*;

  always_comb begin
    if (cnt_i < thresh_i)       kind_o = SLOT_HIGH;
    else if (cnt_i == thresh_i) kind_o = SLOT_EDGE;
    else                        kind_o = SLOT_LOW;
  end
endmodule

// File: rtl/dpwm_fine_slots.sv
module dpwm_fine_slots #(
  parameter int unsigned FINE_W = 2,
  localparam int unsigned SLOTS = 1 << FINE_W
) (
  input  dpwm_pkg::slot_kind_e kind_i,
  input  logic [FINE_W-1:0]    frac_i,
  output logic [SLOTS-1:0]     word_o
);
  import dpwm_pkg::*;

  // slot i (first in time = MSB) is lit in the edge cycle when i < frac
  for (genvar i = 0; i < SLOTS; i++) begin : g_slot
    assign word_o[SLOTS-1-i] = (kind_i == SLOT_HIGH) ||
      ((kind_i == SLOT_EDGE) && ((FINE_W+1)'(i) < {1'b0, frac_i}));
  end
endmodule

// File: rtl/dpwm_hybrid.sv
module dpwm_hybrid #(
  parameter int unsigned DUTY_W = dpwm_pkg::DUTY_W_DEF,
  parameter int unsigned FINE_W = dpwm_pkg::FINE_W_DEF,
  localparam int unsigned CW    = DUTY_W - FINE_W,
  localparam int unsigned SLOTS = 1 << FINE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DUTY_W-1:0] duty_i,
  output logic              coarse_o,
  output logic [SLOTS-1:0]  slot_word_o,
  output logic              period_start_o
);
  import dpwm_pkg::*;

  logic [CW-1:0]     cnt;
  logic [DUTY_W-1:0] duty_act;
  logic              wrap;
  slot_kind_e        kind;
  logic [SLOTS-1:0]  word_next;

  dpwm_period_ctr #(.DUTY_W(DUTY_W), .FINE_W(FINE_W)) u_ctr (
    .clk(clk), .rst(rst), .duty_i(duty_i),
    .cnt_o(cnt), .duty_o(duty_act), .wrap_o(wrap)
  );

  dpwm_coarse_cmp #(.CW(CW)) u_cmp (
    .cnt_i(cnt), .thresh_i(duty_act[DUTY_W-1:FINE_W]), .kind_o(kind)
  );

  dpwm_fine_slots #(.FINE_W(FINE_W)) u_fine (
    .kind_i(kind), .frac_i(duty_act[FINE_W-1:0]), .word_o(word_next)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      coarse_o       <= 1'b0;
      slot_word_o    <= '0;
      period_start_o <= 1'b0;
    end else begin
      coarse_o       <= (kind == SLOT_HIGH);
      slot_word_o    <= word_next;
      period_start_o <= (cnt == '0);
    end
  end

  assert_strobe_single_R2: assert property (@(posedge clk) disable iff (rst)
    period_start_o |=> !period_start_o);

  assert_coarse_full_word_R4: assert property (@(posedge clk) disable iff (rst)
    coarse_o |-> (slot_word_o == '1));

  assert_word_is_prefix_R5: assert property (@(posedge clk) disable iff (rst)
    ((SLOTS'(slot_word_o << 1) & ~slot_word_o) == '0));

  assert_fall_after_start_R3: assert property (@(posedge clk) disable iff (rst)
    $fell(coarse_o) |-> !period_start_o);
endmodule

// File: tb/dpwm_hybrid_test.sv
module dpwm_hybrid_test;
  localparam int CLK_PERIOD = 10;
  localparam int PERIOD_CYC = 256;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [9:0] duty_i = '0;
  logic       coarse_o;
  logic [3:0] slot_word_o;
  logic       period_start_o;

  int checks = 0;
  int fails  = 0;
  int exp_q[$];
  bit done = 0;

  dpwm_hybrid uut (
    .clk(clk), .rst(rst), .duty_i(duty_i),
    .coarse_o(coarse_o), .slot_word_o(slot_word_o), .period_start_o(period_start_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // monitor: rebuilds each period slot by slot and scores it
  initial begin
    bit open = 0;
    int len = 0, hi = 0, chi = 0, partial = 0;
    bit seen_low = 0, gap = 0;
    forever begin
      @(negedge clk);
      if (rst) continue;
      if (period_start_o) begin
        if (open) begin
          int e;
          e = (exp_q.size() > 0) ? exp_q.pop_front() : -1;
          check(len == PERIOD_CYC, "R2 period length", len, PERIOD_CYC);
          check(chi == (e >> 2), "R3 coarse high cycles", chi, e >> 2);
          check(hi == e, "R6 high slots", hi, e);
          check(!gap, "R6 single pulse from slot 0", gap, 0);
          check(partial == (((e % 4) != 0) ? 1 : 0), "R5 partial words", partial,
                ((e % 4) != 0) ? 1 : 0);
          if (e == 0)    check(hi == 0, "R7 zero duty all low", hi, 0);
          if (e == 1023) check(hi == 1023, "R7 full-scale duty", hi, 1023);
        end
        open = 1; len = 0; hi = 0; chi = 0; partial = 0; seen_low = 0; gap = 0;
      end
      if (open) begin
        len++;
        if (coarse_o) chi++;
        if (coarse_o && slot_word_o != 4'hF) gap = 1; // R4
        if (slot_word_o != 4'h0 && slot_word_o != 4'hF) partial++;
        for (int b = 3; b >= 0; b--) begin
          if (slot_word_o[b]) begin
            hi++;
            if (seen_low) gap = 1;
          end else seen_low = 1;
        end
      end
    end
  end

  task automatic wait_start();
    do @(negedge clk); while (!period_start_o);
  endtask

  // driver: sets a duty word just after a period starts; it applies next period
  task automatic drive(input int d);
    wait_start();
    duty_i = 10'(d);
    exp_q.push_back(d);
  endtask

  initial begin
    exp_q.push_back(0); // R1: first period after reset uses a cleared duty
    duty_i = 10'd700;   // must not leak through reset
    repeat (3) @(negedge clk);
    check(coarse_o == 0 && slot_word_o == 0 && period_start_o == 0,
          "R1 outputs low in reset", {coarse_o, slot_word_o, period_start_o}, 0);
    rst = 0;
    drive(0);
    drive(1);
    drive(2);
    drive(3);
    drive(4);
    drive(5);
    drive(7);
    drive(256);
    drive(511);
    drive(512);
    drive(1020);
    drive(1022);
    drive(1023);
    // R8: change the word mid-period; only the final value is captured
    wait_start();
    duty_i = 10'd900;
    repeat (120) @(negedge clk);
    duty_i = 10'd33;
    exp_q.push_back(33);
    drive(6);
    wait_start();
    wait_start();
    check(exp_q.size() == 0, "R8 all periods scored", exp_q.size(), 0);
    done = 1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 200000) begin
      @(negedge clk);
      cyc++;
    end
    if (!done) check(0, "watchdog", cyc, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule